// File: doc/BRIEF.md
# Per-Source Software Interrupt Pending Tracker

This block holds the pending state of software-raised interrupts toward one target processor. For every interrupt number it keeps a bitmap with one bit per requesting source processor, plus a summary pending flag that the delivery logic consumes. Software reaches the bitmaps through two byte-wide register windows. A write to the set window merges source bits into the bitmap. A write to the clear window removes the source bits that are written as one. A read of either window returns the bitmap.

Each access is gated by the security state of the request. When the security extension is enabled, a non-secure request that targets an interrupt whose group bit is 0 reads as zero and cannot change anything. A small read-response state machine returns read data one cycle after the request. It has two states. `ST_IDLE` means no response is due. `ST_RESP` means `rd_valid` is high and `rd_data` carries the response. A read request moves `ST_IDLE` to `ST_RESP`. Another read in `ST_RESP` keeps the machine there. Any cycle without a read request returns it to `ST_IDLE`.

Top module: `sgi_pend_tracker`

## Requirements
- R1: The clear window occupies addresses 0xF10 to 0xF1F and the set window occupies 0xF20 to 0xF2F. The interrupt number is the address minus the window base, so 0xF13 and 0xF23 both address interrupt 3.
- R2: A permitted clear-window write replaces the bitmap with bitmap AND NOT data, which removes every source bit written as 1.
- R3: After a permitted clear-window write, the summary flag is 0 if the resulting bitmap is zero. Otherwise the flag keeps its value.
- R4: A permitted set-window write replaces the bitmap with bitmap OR data and sets that interrupt's summary flag in the following cycle.
- R5: A permitted set-window write with data 0x00 leaves the bitmap unchanged and still sets the summary flag.
- R6: A read request in cycle N gives `rd_valid`=1 in cycle N+1, with `rd_data` equal to the bitmap of the addressed interrupt. `rd_data` is 0 whenever `rd_valid` is 0.
- R7: With `sec_ext_en`=1, a request with `req_secure`=0 to an interrupt whose `sgi_group` bit is 0 reads as 0x00, and its set and clear writes change neither the bitmap nor the flag.
- R8: An access is permitted if the security extension is off, or the request is secure, or the interrupt's group bit is 1.
- R9: Addresses outside both windows read as 0x00 and their writes change no state.
- R10: Synchronous reset (`rst_n`=0) clears every bitmap and every summary flag, and sets `rd_valid` to 0.
- R11: A summary flag is 1 whenever any bit of its bitmap is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_ext_en | input | 1 | Security extension enabled |
| sgi_group | input | NUM_SGI | Group bit per interrupt (0 = secure group) |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Request is secure |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | SRC_W | Write data, one bit per source processor |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | SRC_W | Read response bitmap |
| sgi_pend | output | NUM_SGI | Summary pending flag per interrupt |

## Verification
The assertions check the following properties on every cycle:
- A set bitmap bit always implies its summary flag.
- Denied writes and writes outside both windows leave all bitmaps and flags unchanged.
- Denied reads return zero.
- The read response arrives exactly one cycle after its request.
- A permitted set always raises its flag.

Only the bench scenarios can show the arithmetic values involved:
- the partial clear that keeps the flag up;
- a clear whose result is zero, which drops the flag;
- a set with zero data, which raises the flag over an empty bitmap;
- the exact window boundaries;
- a grant through the group bit, or with the extension turned off.

// File: rtl/sgi_trk_pkg.sv
`timescale 1ns/1ps
package sgi_trk_pkg;
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_CLR  = 2'd1,
        WIN_SET  = 2'd2
    } win_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/sgi_trk_decode.sv
`timescale 1ns/1ps
module sgi_trk_decode
    import sgi_trk_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_SGI = 16,
    parameter logic [ADDR_W-1:0] CLR_BASE = 12'hF10,
    parameter logic [ADDR_W-1:0] SET_BASE = 12'hF20,
    localparam int IDX_W = $clog2(NUM_SGI)
) (
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_secure,
    input  logic               sec_ext_en,
    input  logic [NUM_SGI-1:0] sgi_group,
    output win_e               win,
    output logic [IDX_W-1:0]   idx,
    output logic               permit
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_SGI);

    logic [ADDR_W-1:0] clr_off;
    logic [ADDR_W-1:0] set_off;
    logic              in_clr;
    logic              in_set;

    always_comb begin
        clr_off = req_addr - CLR_BASE;
        set_off = req_addr - SET_BASE;
        in_clr  = (req_addr >= CLR_BASE) && (clr_off < SPAN);
        in_set  = (req_addr >= SET_BASE) && (set_off < SPAN);
        if (in_clr) begin
            win = WIN_CLR;
            idx = clr_off[IDX_W-1:0];
        end else if (in_set) begin
            win = WIN_SET;
            idx = set_off[IDX_W-1:0];
        end else begin
            win = WIN_NONE;
            idx = '0;
        end
        permit = !sec_ext_en || req_secure || sgi_group[idx];
    end
endmodule

// File: rtl/sgi_trk_slot.sv
`timescale 1ns/1ps
module sgi_trk_slot #(
    parameter int SRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [SRC_W-1:0] wdata,
    output logic [SRC_W-1:0] bmp,
    output logic             pend
);
    logic [SRC_W-1:0] cleared;

    always_comb cleared = bmp & ~wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bmp  <= '0;
            pend <= 1'b0;
        end else if (set_en) begin
            bmp  <= bmp | wdata;
            pend <= 1'b1;
        end else if (clr_en) begin
            bmp <= cleared;
            if (cleared == '0) begin
                pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sgi_pend_tracker.sv
`timescale 1ns/1ps
module sgi_pend_tracker
    import sgi_trk_pkg::*;
#(
    parameter int NUM_SGI = 16,
    parameter int SRC_W   = 8,
    parameter int ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] CLR_BASE = 12'hF10,
    parameter logic [ADDR_W-1:0] SET_BASE = 12'hF20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_ext_en,
    input  logic [NUM_SGI-1:0] sgi_group,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_secure,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [SRC_W-1:0]   req_wdata,
    output logic               rd_valid,
    output logic [SRC_W-1:0]   rd_data,
    output logic [NUM_SGI-1:0] sgi_pend
);
    localparam int IDX_W = $clog2(NUM_SGI);

    win_e                     win;
    logic [IDX_W-1:0]         idx;
    logic                     permit;
    logic [SRC_W-1:0]         bmp [NUM_SGI];
    logic [NUM_SGI*SRC_W-1:0] bmp_flat;
    logic                     rd_req;
    rd_state_e                state_q;
    rd_state_e                state_d;

    sgi_trk_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_SGI (NUM_SGI),
        .CLR_BASE(CLR_BASE),
        .SET_BASE(SET_BASE)
    ) u_decode (
        .req_addr  (req_addr),
        .req_secure(req_secure),
        .sec_ext_en(sec_ext_en),
        .sgi_group (sgi_group),
        .win       (win),
        .idx       (idx),
        .permit    (permit)
    );

    for (genvar g = 0; g < NUM_SGI; g++) begin : g_slot
        logic hit;
        assign hit = req_valid && req_write && permit && (idx == IDX_W'(g));
        sgi_trk_slot #(.SRC_W(SRC_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .set_en(hit && (win == WIN_SET)),
            .clr_en(hit && (win == WIN_CLR)),
            .wdata (req_wdata),
            .bmp   (bmp[g]),
            .pend  (sgi_pend[g])
        );
        assign bmp_flat[g*SRC_W +: SRC_W] = bmp[g];
    end

    assign rd_req = req_valid && !req_write;

    // Next-state logic of the read-response machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_req)  state_d = ST_RESP;
            ST_RESP: if (!rd_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register: read data is captured together with the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_req && permit && (win != WIN_NONE)) begin
            rd_data <= bmp[idx];
        end else begin
            rd_data <= '0;
        end
    end

    assign rd_valid = (state_q == ST_RESP);
endmodule

// File: rtl/sgi_pend_tracker_chk.sv
`timescale 1ns/1ps
module sgi_pend_tracker_chk #(
    parameter int NUM_SGI = 16,
    parameter int SRC_W   = 8,
    parameter int ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] CLR_BASE = 12'hF10,
    parameter logic [ADDR_W-1:0] SET_BASE = 12'hF20,
    localparam int IDX_W = $clog2(NUM_SGI)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sec_ext_en,
    input logic [NUM_SGI-1:0]       sgi_group,
    input logic                     req_valid,
    input logic                     req_write,
    input logic                     req_secure,
    input logic [ADDR_W-1:0]        req_addr,
    input logic [SRC_W-1:0]         req_wdata,
    input logic                     rd_valid,
    input logic [SRC_W-1:0]         rd_data,
    input logic [NUM_SGI-1:0]       sgi_pend,
    input logic [NUM_SGI*SRC_W-1:0] bmp_flat
);
    logic [IDX_W-1:0] a_idx;
    logic             in_clr;
    logic             in_set;
    logic             denied;

    assign a_idx  = req_addr[IDX_W-1:0];
    assign in_clr = (req_addr >= CLR_BASE) && (req_addr < CLR_BASE + ADDR_W'(NUM_SGI));
    assign in_set = (req_addr >= SET_BASE) && (req_addr < SET_BASE + ADDR_W'(NUM_SGI));
    assign denied = sec_ext_en && !req_secure && !sgi_group[a_idx];

    // R7
    denied_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && denied |=> $stable(bmp_flat) && $stable(sgi_pend));

    // R7
    denied_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && denied |=> rd_data == '0);

    // R9
    outside_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && !in_clr && !in_set |=> $stable(bmp_flat) && $stable(sgi_pend));

    // R6
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rd_valid);

    // R6
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    // R6
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0);

    // R4
    set_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && in_set && !denied |=> sgi_pend[$past(a_idx)]);

    for (genvar g = 0; g < NUM_SGI; g++) begin : g_inv
        // R11
        pend_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bmp_flat[g*SRC_W +: SRC_W] != '0) |-> sgi_pend[g]);
    end
endmodule

bind sgi_pend_tracker sgi_pend_tracker_chk #(
    .NUM_SGI (NUM_SGI),
    .SRC_W   (SRC_W),
    .ADDR_W  (ADDR_W),
    .CLR_BASE(CLR_BASE),
    .SET_BASE(SET_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_ext_en(sec_ext_en),
    .sgi_group (sgi_group),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_secure(req_secure),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .sgi_pend  (sgi_pend),
    .bmp_flat  (bmp_flat)
);

// File: tb/sgi_pend_tracker_bench.sv
`timescale 1ns/1ps
module sgi_pend_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_ext_en = 1'b0;
    logic [15:0] sgi_group = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b1;
    logic [11:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [15:0] sgi_pend;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sgi_pend_tracker u_sgi_pend_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_ext_en(sec_ext_en),
        .sgi_group (sgi_group),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_secure(req_secure),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .sgi_pend  (sgi_pend)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic sec);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_secure = sec;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic sec, output logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_secure = sec;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 rd_valid", 32'(rd_valid), 32'd1);
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R10 pend after reset", 32'(sgi_pend), 32'h0);
        chk("R10 rd_valid after reset", 32'(rd_valid), 32'd0);
        rd(12'hF20, 1'b1, d);
        chk("R10 bitmap after reset", 32'(d), 32'h0);
    endtask

    task automatic t_set();
        logic [7:0] d;
        wr(12'hF23, 8'h05, 1'b1);
        chk("R4 pend after set", 32'(sgi_pend), 32'h0008);
        rd(12'hF13, 1'b1, d);
        chk("R1 read via clear window", 32'(d), 32'h05);
        @(negedge clk);
        chk("R6 rd_data zero when idle", 32'({rd_valid, rd_data}), 32'h0);
        wr(12'hF23, 8'h22, 1'b1);
        rd(12'hF23, 1'b1, d);
        chk("R4 OR merge", 32'(d), 32'h27);
    endtask

    task automatic t_clear();
        logic [7:0] d;
        wr(12'hF13, 8'h05, 1'b1);
        rd(12'hF23, 1'b1, d);
        chk("R2 and-not clear", 32'(d), 32'h22);
        chk("R3 pend kept on partial clear", 32'(sgi_pend[3]), 32'd1);
        wr(12'hF13, 8'h22, 1'b1);
        chk("R3 pend dropped on empty", 32'(sgi_pend), 32'h0);
    endtask

    task automatic t_zero_set();
        logic [7:0] d;
        wr(12'hF27, 8'h00, 1'b1);
        chk("R5 pend on zero-data set", 32'(sgi_pend), 32'h0080);
        rd(12'hF27, 1'b1, d);
        chk("R5 bitmap unchanged", 32'(d), 32'h0);
        wr(12'hF17, 8'h00, 1'b1);
        chk("R3 clear leaves empty map", 32'(sgi_pend), 32'h0);
    endtask

    task automatic t_gating();
        logic [7:0] d;
        sec_ext_en = 1'b1;
        sgi_group  = 16'h0200;
        wr(12'hF25, 8'h81, 1'b1);
        rd(12'hF25, 1'b0, d);
        chk("R7 non-secure read of group 0", 32'(d), 32'h0);
        wr(12'hF15, 8'h81, 1'b0);
        rd(12'hF25, 1'b1, d);
        chk("R7 non-secure clear ignored", 32'(d), 32'h81);
        wr(12'hF26, 8'hFF, 1'b0);
        chk("R7 non-secure set ignored", 32'(sgi_pend), 32'h0020);
        wr(12'hF29, 8'h10, 1'b0);
        rd(12'hF19, 1'b0, d);
        chk("R8 group 1 non-secure access", 32'(d), 32'h10);
        sec_ext_en = 1'b0;
        rd(12'hF15, 1'b0, d);
        chk("R8 extension off", 32'(d), 32'h81);
    endtask

    task automatic t_outside();
        logic [7:0] d;
        wr(12'hF30, 8'hFF, 1'b1);
        wr(12'hF0F, 8'hFF, 1'b1);
        chk("R9 outside writes ignored", 32'(sgi_pend), 32'h0220);
        rd(12'hF30, 1'b1, d);
        chk("R9 outside read zero", 32'(d), 32'h0);
        wr(12'hF2F, 8'h80, 1'b1);
        chk("R1 last set slot", 32'(sgi_pend), 32'h8220);
        rd(12'hF1F, 1'b1, d);
        chk("R1 last clear slot read", 32'(d), 32'h80);
        wr(12'hF10, 8'hFF, 1'b1);
        chk("R1 first clear slot on empty", 32'(sgi_pend), 32'h8220);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set();
        t_clear();
        t_zero_set();
        t_gating();
        t_outside();
        repeat (2) @(negedge clk);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end
endmodule